// File: doc/BRIEF.md
# Deferred Column Allocation Table

This block sits in the rename stage beside a compacted dependency matrix. It keeps one entry per architectural register. Each entry holds a two-bit state and an index. A register is pending-no-column (the index is the scheduler row of its producer), owns-column (the index is a matrix column), value-ready, or column-released. A producer gets a matrix column only when its first consumer is dispatched. Producers with no consumers therefore never use one of the scarce columns.

Each cycle a group of up to IW instructions is presented. Each instruction has up to two sources and one destination. Sources are looked up and dependencies within the group are resolved. Free columns are granted from a bitmap, and destinations are recorded. One cycle later the block returns three things. Each instruction gets a matrix row bit pattern. Each newly allocated column gets a subscribe command naming the producer row and the column. Completion and release events are echoed as column clear and column release commands. When the group needs more columns than are free, the group is held back through a combinational stall.

Top module: `wake_col_table`

## Requirements
- R1: After reset every register reads as value-ready, so any source produces no dependency bit. All NCOL columns are free, and all registered outputs and the stall are low.
- R2: A dispatched destination is recorded as pending with its scheduler row, and no column is granted. The first later consumer of that register gets a column. A subscribe command then carries the producer row and that column, and the consumer's row bit for the column is set.
- R3: A source whose register already owns a column sets that column's bit in its row pattern and issues no subscribe command.
- R4: A completion event names a register and the producer's row (no column) or column (has column). A matching entry becomes value-ready, and later sources of that register produce no bit. A completion that carries a column emits a clear command for that column one cycle later.
- R5: Columns are granted lowest-numbered first. They go to new allocations in source order: instruction 0 source 0, instruction 0 source 1, instruction 1 source 0, and so on. Sources that reach the same producer in one group share one column and one subscribe command.
- R6: When several instructions in a group write the same register, only the last of them updates the table.
- R7: A source that names the destination of an earlier instruction in the same group uses that instruction's row instead of the table contents. A column granted this way is recorded in the table as owned by that producer.
- R8: If a group needs more new columns than are free, the stall output is high in the same cycle. No row pattern or subscribe command is produced, and the lookup and destination state stay unchanged.
- R9: A release event returns a column to the free list from the next cycle on. Any register that owns that column becomes column-released, and such a register reads as no dependency. The release is echoed one cycle later.
- R10: Completion does not free a column; only a release does, so a producer may broadcast again on it.
- R11: A completion or release that arrives in the same cycle as a lookup of the same register takes effect for that lookup, which then sees no dependency.
- R12: All results of an accepted group appear exactly one cycle after the group is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | A rename group is presented |
| disp_dst_vld | input | IW | Destination present, per instruction |
| disp_dst_reg | input | IW x log2(NARCH) | Destination register, per instruction |
| disp_row | input | IW x log2(WS) | Scheduler row given to each instruction |
| disp_src_vld | input | 2*IW | Source present; index 2*i+s |
| disp_src_reg | input | 2*IW x log2(NARCH) | Source register; index 2*i+s |
| cmp_valid | input | 1 | Producer completion event |
| cmp_reg | input | log2(NARCH) | Register whose producer completed |
| cmp_has_col | input | 1 | Producer owns a column (cmp_idx is a column) |
| cmp_idx | input | log2(WS) | Producer column or scheduler row |
| rel_valid | input | 1 | Column release event |
| rel_col | input | log2(NCOL) | Column being released |
| grp_stall | output | 1 | Group held back for lack of columns |
| o_valid | output | 1 | Group results valid |
| o_dep_bits | output | IW x NCOL | Matrix row pattern per instruction |
| o_sub_vld | output | 2*IW | Subscribe command per source slot |
| o_sub_row | output | 2*IW x log2(WS) | Producer row to receive the column |
| o_sub_col | output | 2*IW x log2(NCOL) | Column granted |
| o_clr_vld | output | 1 | Column clear command |
| o_clr_col | output | log2(NCOL) | Column to clear |
| o_rel_vld | output | 1 | Column release command |
| o_rel_col | output | log2(NCOL) | Column released |

## Verification
The bench builds the table with two instructions per group, eight registers, sixteen rows and only four columns. A single group can then ask for all four columns at once, and exhaustion, stalls and release recovery come up often. With eight registers, random groups frequently collide on registers. This exercises write-after-write within a group, sharing of a column by sources within the group, and completions or releases that land in the same cycle as a lookup.

// File: rtl/wat_pkg.sv
package wat_pkg;
  typedef enum logic [1:0] {
    ST_UNALLOC = 2'd0,
    ST_ALLOC   = 2'd1,
    ST_READY   = 2'd2,
    ST_DEALLOC = 2'd3
  } wst_e;
endpackage

// File: rtl/grp_dep_check.sv
module grp_dep_check #(
  parameter int IW = 2,
  parameter int RW = 3,
  parameter int SW = 1,
  parameter int NSRC = 2 * IW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IW-1:0]             dst_vld,
  input  logic [IW-1:0][RW-1:0]     dst_reg,
  input  logic [NSRC-1:0]           src_vld,
  input  logic [NSRC-1:0][RW-1:0]   src_reg,
  output logic [NSRC-1:0]           src_hit,
  output logic [NSRC-1:0][SW-1:0]   src_from,
  output logic [IW-1:0]             dst_last
);
  // latest earlier writer in the group wins for each source
  always_comb begin
    for (int f = 0; f < NSRC; f++) begin
      src_hit[f]  = 1'b0;
      src_from[f] = '0;
      for (int k = 0; k < IW; k++) begin
        if (k < f / 2 && dst_vld[k] && src_vld[f] && dst_reg[k] == src_reg[f]) begin
          src_hit[f]  = 1'b1;
          src_from[f] = SW'(k);
        end
      end
    end
    for (int i = 0; i < IW; i++) begin
      dst_last[i] = dst_vld[i];
      for (int k = 0; k < IW; k++) begin
        if (k > i && dst_vld[k] && dst_reg[k] == dst_reg[i]) dst_last[i] = 1'b0;
      end
    end
  end

  for (genvar f = 0; f < NSRC; f++) begin : g_chk
    // R7: an in-group producer is always an earlier instruction
    a_r7_from_earlier: assert property (@(posedge clk) disable iff (rst)
      src_hit[f] |-> (int'(src_from[f]) < f / 2));
  end
endmodule

// File: rtl/col_freelist.sv
module col_freelist #(
  parameter int NCOL = 8,
  parameter int NREQ = 4,
  parameter int CW = 3,
  parameter int KW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [KW-1:0]            take_n,
  input  logic                     rel_vld,
  input  logic [CW-1:0]            rel_col,
  output logic [NREQ-1:0][CW-1:0]  free_cols,
  output logic [KW-1:0]            free_cnt
);
  logic [NCOL-1:0] free_q, free_d, scan;
  logic            found;

  always_comb begin
    scan     = free_q;
    free_cnt = '0;
    for (int k = 0; k < NREQ; k++) begin
      free_cols[k] = '0;
      found        = 1'b0;
      for (int c = 0; c < NCOL; c++) begin
        if (!found && scan[c]) begin
          found        = 1'b1;
          free_cols[k] = CW'(c);
        end
      end
      if (found) begin
        scan[free_cols[k]] = 1'b0;
        free_cnt           = free_cnt + 1'b1;
      end
    end
    free_d = free_q;
    for (int k = 0; k < NREQ; k++) begin
      if (k < int'(take_n)) free_d[free_cols[k]] = 1'b0;
    end
    if (rel_vld) free_d[rel_col] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= free_d;
  end

  a_r8_no_overgrant: assert property (@(posedge clk) disable iff (rst)
    take_n <= free_cnt);
  a_r5_grant_marks_busy: assert property (@(posedge clk) disable iff (rst)
    (take_n != '0 && !(rel_vld && rel_col == free_cols[0])) |=> !free_q[$past(free_cols[0])]);
  a_r9_release_frees: assert property (@(posedge clk) disable iff (rst)
    rel_vld |=> free_q[$past(rel_col)]);
endmodule

// File: rtl/wake_col_table.sv
module wake_col_table
  import wat_pkg::*;
#(
  parameter int NARCH = 8,
  parameter int WS    = 16,
  parameter int NCOL  = 8,
  parameter int IW    = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   disp_valid,
  input  logic [IW-1:0]                          disp_dst_vld,
  input  logic [IW-1:0][$clog2(NARCH)-1:0]       disp_dst_reg,
  input  logic [IW-1:0][$clog2(WS)-1:0]          disp_row,
  input  logic [2*IW-1:0]                        disp_src_vld,
  input  logic [2*IW-1:0][$clog2(NARCH)-1:0]     disp_src_reg,
  input  logic                                   cmp_valid,
  input  logic [$clog2(NARCH)-1:0]               cmp_reg,
  input  logic                                   cmp_has_col,
  input  logic [$clog2(WS)-1:0]                  cmp_idx,
  input  logic                                   rel_valid,
  input  logic [$clog2(NCOL)-1:0]                rel_col,
  output logic                                   grp_stall,
  output logic                                   o_valid,
  output logic [IW-1:0][NCOL-1:0]                o_dep_bits,
  output logic [2*IW-1:0]                        o_sub_vld,
  output logic [2*IW-1:0][$clog2(WS)-1:0]        o_sub_row,
  output logic [2*IW-1:0][$clog2(NCOL)-1:0]      o_sub_col,
  output logic                                   o_clr_vld,
  output logic [$clog2(NCOL)-1:0]                o_clr_col,
  output logic                                   o_rel_vld,
  output logic [$clog2(NCOL)-1:0]                o_rel_col
);
  localparam int RW   = $clog2(NARCH);
  localparam int XW   = $clog2(WS);
  localparam int CW   = $clog2(NCOL);
  localparam int NSRC = 2 * IW;
  localparam int SW   = (IW > 1) ? $clog2(IW) : 1;
  localparam int KW   = $clog2(NSRC + 1);

  wst_e            st_q [NARCH];
  wst_e            st_d [NARCH];
  logic [XW-1:0]   ix_q [NARCH];
  logic [XW-1:0]   ix_d [NARCH];

  logic [NSRC-1:0]          src_hit;
  logic [NSRC-1:0][SW-1:0]  src_from;
  logic [IW-1:0]            dst_last;
  logic [NSRC-1:0][CW-1:0]  free_cols;
  logic [KW-1:0]            free_cnt, need_n, take_n;

  wst_e                     lk_st [NSRC];
  logic [XW-1:0]            lk_ix [NSRC];
  logic [NSRC-1:0]          need, dep, ing, first, found;
  logic [NSRC-1:0][CW-1:0]  src_col;
  logic [NSRC-1:0][XW-1:0]  sub_row;
  logic [IW-1:0]            prod_al;
  logic [IW-1:0][CW-1:0]    prod_col;
  logic [IW-1:0][NCOL-1:0]  bits_d;
  logic                     cmp_hit, go;
  logic [KW-1:0]            rnk;

  grp_dep_check #(.IW(IW), .RW(RW), .SW(SW), .NSRC(NSRC)) i_dep (
    .clk(clk), .rst(rst),
    .dst_vld(disp_dst_vld), .dst_reg(disp_dst_reg),
    .src_vld(disp_src_vld), .src_reg(disp_src_reg),
    .src_hit(src_hit), .src_from(src_from), .dst_last(dst_last)
  );

  col_freelist #(.NCOL(NCOL), .NREQ(NSRC), .CW(CW), .KW(KW)) i_free (
    .clk(clk), .rst(rst), .take_n(take_n),
    .rel_vld(rel_valid), .rel_col(rel_col),
    .free_cols(free_cols), .free_cnt(free_cnt)
  );

  // completion applies only to the producer the entry still names
  always_comb begin
    cmp_hit = cmp_valid &&
      ((st_q[cmp_reg] == ST_ALLOC   &&  cmp_has_col && ix_q[cmp_reg] == cmp_idx) ||
       (st_q[cmp_reg] == ST_UNALLOC && !cmp_has_col && ix_q[cmp_reg] == cmp_idx));
  end

  // lookup, same-cycle event bypass, key dedupe and column ranking
  always_comb begin
    rnk = '0;
    for (int f = 0; f < NSRC; f++) begin
      lk_st[f] = st_q[disp_src_reg[f]];
      lk_ix[f] = ix_q[disp_src_reg[f]];
      if (cmp_hit && cmp_reg == disp_src_reg[f]) lk_st[f] = ST_READY;
      if (rel_valid && lk_st[f] == ST_ALLOC && lk_ix[f] == XW'(rel_col)) lk_st[f] = ST_DEALLOC;
      ing[f]  = disp_src_vld[f] && src_hit[f];
      need[f] = ing[f] || (disp_src_vld[f] && lk_st[f] == ST_UNALLOC);
      dep[f]  = !ing[f] && disp_src_vld[f] && lk_st[f] == ST_ALLOC;
      first[f] = need[f];
      found[f] = 1'b0;
      src_col[f] = dep[f] ? lk_ix[f][CW-1:0] : '0;
      for (int g = 0; g < f; g++) begin
        if (!found[f] && need[g] && need[f] && ing[g] == ing[f] &&
            (ing[f] ? src_from[g] == src_from[f] : disp_src_reg[g] == disp_src_reg[f])) begin
          found[f]   = 1'b1;
          first[f]   = 1'b0;
          src_col[f] = src_col[g];
        end
      end
      if (first[f]) begin
        if (int'(rnk) < NSRC) src_col[f] = free_cols[rnk];
        rnk = rnk + 1'b1;
      end
      sub_row[f] = ing[f] ? disp_row[src_from[f]] : lk_ix[f];
    end
    need_n    = rnk;
    grp_stall = disp_valid && (need_n > free_cnt);
    go        = disp_valid && !grp_stall;
    take_n    = go ? need_n : '0;
  end

  // columns granted to producers inside the group, and row patterns
  always_comb begin
    prod_al  = '0;
    prod_col = '0;
    bits_d   = '0;
    for (int f = 0; f < NSRC; f++) begin
      if (first[f] && ing[f] && !prod_al[src_from[f]]) begin
        prod_al[src_from[f]]  = 1'b1;
        prod_col[src_from[f]] = src_col[f];
      end
      if (go && (need[f] || dep[f])) bits_d[f / 2][src_col[f]] = 1'b1;
    end
  end

  // next table state: events first, then allocations, then destinations
  always_comb begin
    st_d = st_q;
    ix_d = ix_q;
    if (cmp_hit) st_d[cmp_reg] = ST_READY;
    if (rel_valid) begin
      for (int r = 0; r < NARCH; r++) begin
        if (st_q[r] == ST_ALLOC && ix_q[r] == XW'(rel_col)) st_d[r] = ST_DEALLOC;
      end
    end
    if (go) begin
      for (int f = 0; f < NSRC; f++) begin
        if (first[f] && !ing[f]) begin
          st_d[disp_src_reg[f]] = ST_ALLOC;
          ix_d[disp_src_reg[f]] = XW'(src_col[f]);
        end
      end
      for (int i = 0; i < IW; i++) begin
        if (dst_last[i]) begin
          st_d[disp_dst_reg[i]] = prod_al[i] ? ST_ALLOC : ST_UNALLOC;
          ix_d[disp_dst_reg[i]] = prod_al[i] ? XW'(prod_col[i]) : disp_row[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NARCH; r++) begin
        st_q[r] <= ST_READY;
        ix_q[r] <= '0;
      end
      o_valid    <= 1'b0;
      o_dep_bits <= '0;
      o_sub_vld  <= '0;
      o_sub_row  <= '0;
      o_sub_col  <= '0;
      o_clr_vld  <= 1'b0;
      o_clr_col  <= '0;
      o_rel_vld  <= 1'b0;
      o_rel_col  <= '0;
    end else begin
      st_q       <= st_d;
      ix_q       <= ix_d;
      o_valid    <= go;
      o_dep_bits <= bits_d;
      o_sub_vld  <= go ? first : '0;
      o_sub_row  <= sub_row;
      o_sub_col  <= src_col;
      o_clr_vld  <= cmp_valid && cmp_has_col;
      o_clr_col  <= cmp_idx[CW-1:0];
      o_rel_vld  <= rel_valid;
      o_rel_col  <= rel_col;
    end
  end

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    grp_stall |=> !o_valid);
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !grp_stall) |=> o_valid);
  a_r9_release_echo: assert property (@(posedge clk) disable iff (rst)
    rel_valid |=> (o_rel_vld && o_rel_col == $past(rel_col)));
  for (genvar f = 0; f < NSRC; f++) begin : g_sub
    // R5: every subscribed column also appears in its consumer's row
    a_r5_sub_in_row: assert property (@(posedge clk) disable iff (rst)
      o_sub_vld[f] |-> o_dep_bits[f / 2][o_sub_col[f]]);
  end
endmodule

// File: tb/test_wake_col_table.sv
`timescale 1ns/1ps
module test_wake_col_table;
  localparam int NA = 8, WSZ = 16, NC = 4, W = 2, NS = 4;
  localparam int UNA = 0, ALC = 1, RDY = 2, DEA = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic            disp_valid;
  logic [W-1:0]    d_dst_vld;
  logic [W-1:0][2:0] d_dst_reg;
  logic [W-1:0][3:0] d_row;
  logic [NS-1:0]   d_src_vld;
  logic [NS-1:0][2:0] d_src_reg;
  logic            cmp_valid, cmp_has_col, rel_valid;
  logic [2:0]      cmp_reg;
  logic [3:0]      cmp_idx;
  logic [1:0]      rel_col;
  logic            grp_stall, o_valid, o_clr_vld, o_rel_vld;
  logic [W-1:0][NC-1:0] o_dep_bits;
  logic [NS-1:0]   o_sub_vld;
  logic [NS-1:0][3:0] o_sub_row;
  logic [NS-1:0][1:0] o_sub_col;
  logic [1:0]      o_clr_col, o_rel_col;

  wake_col_table #(.NARCH(NA), .WS(WSZ), .NCOL(NC), .IW(W)) i_wake_col_table (
    .clk(clk), .rst(rst), .disp_valid(disp_valid),
    .disp_dst_vld(d_dst_vld), .disp_dst_reg(d_dst_reg), .disp_row(d_row),
    .disp_src_vld(d_src_vld), .disp_src_reg(d_src_reg),
    .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_has_col(cmp_has_col), .cmp_idx(cmp_idx),
    .rel_valid(rel_valid), .rel_col(rel_col),
    .grp_stall(grp_stall), .o_valid(o_valid), .o_dep_bits(o_dep_bits),
    .o_sub_vld(o_sub_vld), .o_sub_row(o_sub_row), .o_sub_col(o_sub_col),
    .o_clr_vld(o_clr_vld), .o_clr_col(o_clr_col),
    .o_rel_vld(o_rel_vld), .o_rel_col(o_rel_col)
  );

  int n_chk = 0, n_fail = 0;
  int m_st [NA];
  int m_ix [NA];
  logic [NC-1:0] m_free;
  // expectations
  bit e_stall, e_valid, e_clr, e_rel;
  logic [W-1:0][NC-1:0] e_bits;
  bit [NS-1:0] e_sub;
  int e_srow [NS];
  int e_scol [NS];
  int e_clrc, e_relc;
  int x_st [NA];
  int x_ix [NA];
  logic [NC-1:0] x_free;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    disp_valid = 0; d_dst_vld = '0; d_dst_reg = '0; d_row = '0;
    d_src_vld = '0; d_src_reg = '0;
    cmp_valid = 0; cmp_reg = '0; cmp_has_col = 0; cmp_idx = '0;
    rel_valid = 0; rel_col = '0;
  endtask

  // sequential reference: sources then destination, slot by slot
  task automatic predict();
    int vs [NA];
    int vx [NA];
    logic [NC-1:0] fr;
    bit shortf;
    vs = m_st; vx = m_ix; fr = m_free; shortf = 0;
    e_bits = '0; e_sub = '0;
    for (int f = 0; f < NS; f++) begin e_srow[f] = 0; e_scol[f] = 0; end
    if (cmp_valid) begin
      if ((vs[cmp_reg] == ALC && cmp_has_col && vx[cmp_reg] == int'(cmp_idx)) ||
          (vs[cmp_reg] == UNA && !cmp_has_col && vx[cmp_reg] == int'(cmp_idx)))
        vs[cmp_reg] = RDY;
    end
    if (rel_valid)
      for (int r = 0; r < NA; r++) if (vs[r] == ALC && vx[r] == int'(rel_col)) vs[r] = DEA;
    x_st = vs; x_ix = vx;
    if (disp_valid) begin
      for (int i = 0; i < W; i++) begin
        for (int s = 0; s < 2; s++) begin
          int f = 2 * i + s;
          int r = int'(d_src_reg[f]);
          if (d_src_vld[f]) begin
            if (vs[r] == UNA) begin
              int c = -1;
              for (int k = NC - 1; k >= 0; k--) if (fr[k]) c = k;
              if (c < 0) shortf = 1;
              else begin
                fr[c] = 1'b0; e_sub[f] = 1; e_srow[f] = vx[r]; e_scol[f] = c;
                vs[r] = ALC; vx[r] = c;
              end
            end
            if (vs[r] == ALC) e_bits[i][vx[r]] = 1'b1;
          end
        end
        if (d_dst_vld[i]) begin vs[d_dst_reg[i]] = UNA; vx[d_dst_reg[i]] = int'(d_row[i]); end
      end
    end
    e_stall = disp_valid && shortf;
    e_valid = disp_valid && !shortf;
    if (e_valid) begin x_st = vs; x_ix = vx; x_free = fr; end
    else begin x_free = m_free; e_bits = '0; e_sub = '0; end
    if (rel_valid) x_free[rel_col] = 1'b1;
    e_clr = cmp_valid && cmp_has_col; e_clrc = int'(cmp_idx[1:0]);
    e_rel = rel_valid; e_relc = int'(rel_col);
  endtask

  // inputs already driven just after a falling edge
  task automatic step(string tag);
    predict();
    #1;
    chk(tag, "grp_stall", int'(grp_stall), int'(e_stall));
    @(posedge clk);
    m_st = x_st; m_ix = x_ix; m_free = x_free;
    @(negedge clk);
    chk(tag, "o_valid", int'(o_valid), int'(e_valid));
    chk(tag, "o_dep_bits", int'(o_dep_bits), int'(e_bits));
    for (int f = 0; f < NS; f++) begin
      chk(tag, "o_sub_vld", int'(o_sub_vld[f]), int'(e_sub[f]));
      if (e_sub[f] && o_sub_vld[f]) begin
        chk(tag, "o_sub_row", int'(o_sub_row[f]), e_srow[f]);
        chk(tag, "o_sub_col", int'(o_sub_col[f]), e_scol[f]);
      end
    end
    chk(tag, "o_clr_vld", int'(o_clr_vld), int'(e_clr));
    if (e_clr) chk(tag, "o_clr_col", int'(o_clr_col), e_clrc);
    chk(tag, "o_rel_vld", int'(o_rel_vld), int'(e_rel));
    if (e_rel) chk(tag, "o_rel_col", int'(o_rel_col), e_relc);
    clear_in();
  endtask

  task automatic src(int f, int r);
    disp_valid = 1; d_src_vld[f] = 1'b1; d_src_reg[f] = 3'(r);
  endtask
  task automatic dst(int i, int r, int row);
    disp_valid = 1; d_dst_vld[i] = 1'b1; d_dst_reg[i] = 3'(r); d_row[i] = 4'(row);
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_in();
    for (int r = 0; r < NA; r++) begin m_st[r] = RDY; m_ix[r] = 0; end
    m_free = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "o_valid", int'(o_valid), 0);
    chk("R1", "o_sub_vld", int'(o_sub_vld), 0);
    chk("R1", "grp_stall", int'(grp_stall), 0);
    src(0, 3); src(3, 5); step("R1");
    dst(0, 1, 2); step("R2");
    src(0, 1); dst(0, 2, 5); step("R2");
    src(0, 1); src(2, 1); step("R3");
    dst(0, 4, 7); dst(1, 5, 8); step("R5");
    src(0, 4); src(1, 5); src(2, 4); step("R5");
    dst(0, 6, 9); dst(1, 6, 10); step("R6");
    src(0, 6); step("R6");
    dst(0, 7, 11); step("R8");
    src(0, 7); step("R8");
    src(0, 7); step("R8");
    rel_valid = 1; rel_col = 2'd0; step("R9");
    src(0, 1); src(1, 7); step("R9");
    cmp_valid = 1; cmp_reg = 3'd4; cmp_has_col = 1; cmp_idx = 4'd1; step("R4");
    src(0, 4); step("R4");
    dst(0, 3, 12); step("R10");
    src(0, 3); step("R10");
    rel_valid = 1; rel_col = 2'd2; step("R9");
    cmp_valid = 1; cmp_reg = 3'd6; cmp_has_col = 1; cmp_idx = 4'd3;
    src(0, 6); step("R11");
    rel_valid = 1; rel_col = 2'd0; src(0, 7); step("R11");
    dst(0, 2, 13); src(2, 2); src(3, 2); step("R7");
    src(0, 2); step("R7");
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(9) < 8) begin
        for (int i = 0; i < W; i++) begin
          if ($urandom_range(1)) dst(i, $urandom_range(NA - 1), $urandom_range(WSZ - 1));
          for (int s = 0; s < 2; s++)
            if ($urandom_range(2) != 0) src(2 * i + s, $urandom_range(NA - 1));
        end
      end
      if ($urandom_range(3) == 0) begin
        int r = $urandom_range(NA - 1);
        cmp_valid = 1; cmp_reg = 3'(r);
        cmp_has_col = (m_st[r] == ALC);
        cmp_idx = 4'(m_ix[r]);
      end
      if ($urandom_range(2) == 0 && m_free != '1) begin
        int c;
        do c = $urandom_range(NC - 1); while (m_free[c]);
        rel_valid = 1; rel_col = 2'(c);
      end
      step("R12");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule